// File: doc/BRIEF.md
# Directory Coherence Home-Node Controller

This block is the home-node side of a directory-based coherence scheme for a shared-memory machine of `NUM_PROC` processors. For every memory block it owns, it stores a presence vector with one bit per processor and a dirty bit. When the dirty bit is 0, memory holds a valid copy. When it is 1, memory's copy is stale and exactly one cache holds the block modified.

A remote cache that misses sends a request carrying its processor id, the block index and a read/write flag. The controller looks up the block's directory entry and runs one of four flows: a read or a write, each against a clean or a dirty block. In those flows it sends data to the requester, sends invalidations to sharers and collects their acknowledgments, or fetches the line from the single owner. One transaction is in flight at a time, and new requests are held off with a not-ready signal until the current one completes. The last action of every transaction is a data grant to the requester, and a completion pulse is raised in that same cycle.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every block is clean with an empty presence vector, `req_ready_o` is 1, and `msg_valid_o` and `done_valid_o` are 0.
- R2: A read of a clean block produces, one cycle after acceptance, a data-shared message (`msg_type_o`=1) to the requester. The requester's presence bit is set and the dirty bit stays 0.
- R3: A read of a dirty block owned by another processor first sends a fetch-shared message (type 3) to the owner, one cycle after acceptance. One cycle after a response from that owner, the controller sends data-shared (type 1) to the requester. The dirty bit is cleared and both the owner's and the requester's presence bits are set.
- R4: A write to a clean block sends an invalidation (type 4) to each present processor other than the requester, one per cycle in ascending id order. It then waits until every invalidated processor has acknowledged, and one cycle after that it sends data-exclusive (type 2) to the requester. Presence then holds only the requester, and the dirty bit is 1.
- R5: A write to a clean block with no other sharers sends data-exclusive to the requester one cycle after acceptance.
- R6: A write to a dirty block owned by another processor sends fetch-exclusive (type 5) to the owner. One cycle after the owner responds, it sends data-exclusive to the requester. Presence then holds only the requester, and the dirty bit stays 1.
- R7: Whenever a block's dirty bit is 1, exactly one of its presence bits is set. Later fetches for that block therefore go to that one processor only.
- R8: `req_ready_o` drops the cycle after a request is accepted and returns the cycle after completion. Requests presented while it is 0 are ignored.
- R9: A response is ignored if it comes from a processor that is not being waited on, or arrives while no response is expected.
- R10: A request to a dirty block from its own owner is granted one cycle after acceptance without any fetch. A read from the owner clears the dirty bit.
- R11: `done_valid_o` pulses in the same cycle as the final data message. It carries the requester id, the block, and `done_excl_o`=1 for a write (install modified) or 0 for a read (install shared).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Miss request present |
| req_ready_o | output | 1 | Controller idle, request accepted this cycle |
| req_src_i | input | ID_W | Requesting processor id |
| req_blk_i | input | BLK_W | Block index |
| req_write_i | input | 1 | 1 = write miss, 0 = read miss |
| msg_valid_o | output | 1 | Outgoing message valid |
| msg_type_o | output | 3 | 1 data-shared, 2 data-exclusive, 3 fetch-shared, 4 invalidate, 5 fetch-exclusive |
| msg_dst_o | output | ID_W | Destination processor |
| msg_blk_o | output | BLK_W | Block the message refers to |
| rsp_valid_i | input | 1 | Acknowledgment or owner data return |
| rsp_src_i | input | ID_W | Responding processor |
| done_valid_o | output | 1 | Transaction complete |
| done_src_o | output | ID_W | Requester of the completed transaction |
| done_blk_o | output | BLK_W | Block of the completed transaction |
| done_excl_o | output | 1 | 1 = requester installs modified, 0 = shared |

## Verification
A clean read or an owner re-request completes one cycle after acceptance. Invalidations start one cycle after acceptance and go out one per cycle. A fetch goes out one cycle after acceptance. The grant follows one cycle after either the ack count reaches the number of invalidations sent or the owner's response is sampled. The bench runs a behavioural model that advances on the same rising edge as the design, and it compares ready, message and completion outputs at every falling edge. Any early, late or misdirected message is therefore caught in the exact cycle it appears. Acknowledgments arrive three cycles after each invalidation or fetch, and stray responses are injected both during an owner wait and while idle.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [2:0] {
    MSG_NONE     = 3'd0,
    MSG_DATA_SH  = 3'd1,
    MSG_DATA_EX  = 3'd2,
    MSG_FETCH_SH = 3'd3,
    MSG_INVAL    = 3'd4,
    MSG_FETCH_EX = 3'd5
  } msg_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INV_SEND,
    ST_INV_WAIT,
    ST_FETCH,
    ST_OWN_WAIT,
    ST_GRANT
  } st_e;
endpackage

// File: rtl/dir_store.sv
module dir_store #(
  parameter int NUM_PROC = 4,
  parameter int NUM_BLK  = 8,
  localparam int BLK_W   = $clog2(NUM_BLK)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [BLK_W-1:0]    rd_idx_i,
  output logic [NUM_PROC-1:0] rd_pres_o,
  output logic                rd_dirty_o,
  input  logic                wr_en_i,
  input  logic [BLK_W-1:0]    wr_idx_i,
  input  logic [NUM_PROC-1:0] wr_pres_i,
  input  logic                wr_dirty_i
);
  logic [NUM_PROC-1:0] pres_q [NUM_BLK];
  logic [NUM_BLK-1:0]  dirty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NUM_BLK; b++) pres_q[b] <= '0;
      dirty_q <= '0;
    end else if (wr_en_i) begin
      pres_q[wr_idx_i]  <= wr_pres_i;
      dirty_q[wr_idx_i] <= wr_dirty_i;
    end
  end

  assign rd_pres_o  = pres_q[rd_idx_i];
  assign rd_dirty_o = dirty_q[rd_idx_i];

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_chk
    assert_dirty_single_owner_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dirty_q[b] |-> $onehot(pres_q[b]));
  end
endmodule

// File: rtl/dir_lsb.sv
module dir_lsb #(
  parameter int W      = 4,
  localparam int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             found_o
);
  always_comb begin
    idx_o   = '0;
    found_o = 1'b0;
    for (int k = W - 1; k >= 0; k--) begin
      if (vec_i[k]) begin
        idx_o   = IDX_W'(k);
        found_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dir_popcnt.sv
module dir_popcnt #(
  parameter int W      = 4,
  localparam int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     vec_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int k = 0; k < W; k++) cnt_o = cnt_o + CNT_W'(vec_i[k]);
  end
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl #(
  parameter int NUM_PROC = 4,
  parameter int NUM_BLK  = 8,
  localparam int ID_W    = $clog2(NUM_PROC),
  localparam int BLK_W   = $clog2(NUM_BLK)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [ID_W-1:0]  req_src_i,
  input  logic [BLK_W-1:0] req_blk_i,
  input  logic             req_write_i,
  output logic             msg_valid_o,
  output logic [2:0]       msg_type_o,
  output logic [ID_W-1:0]  msg_dst_o,
  output logic [BLK_W-1:0] msg_blk_o,
  input  logic             rsp_valid_i,
  input  logic [ID_W-1:0]  rsp_src_i,
  output logic             done_valid_o,
  output logic [ID_W-1:0]  done_src_o,
  output logic [BLK_W-1:0] done_blk_o,
  output logic             done_excl_o
);
  import dir_pkg::*;

  localparam int CNT_W = $clog2(NUM_PROC + 1);

  st_e                 state_q, state_d;
  logic [ID_W-1:0]     src_q, owner_q;
  logic [BLK_W-1:0]    blk_q;
  logic                wr_q;
  logic [NUM_PROC-1:0] pend_q, inv_all_q, acked_q;
  logic [CNT_W-1:0]    ack_cnt_q, inv_total_q;

  logic [BLK_W-1:0]    rd_idx;
  logic [NUM_PROC-1:0] rd_pres, wr_pres;
  logic                rd_dirty, wr_en;
  logic [NUM_PROC-1:0] req_oh, src_oh, rsp_oh, inv_oh, others;
  logic [ID_W-1:0]     own_idx, inv_idx;
  logic                own_found, inv_found;
  logic [CNT_W-1:0]    others_cnt;
  logic                accept, inv_phase, ack_hit;
  msg_e                msg_t;

  assign rd_idx = (state_q == ST_IDLE) ? req_blk_i : blk_q;

  dir_store #(.NUM_PROC(NUM_PROC), .NUM_BLK(NUM_BLK)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (rd_idx),
    .rd_pres_o  (rd_pres),
    .rd_dirty_o (rd_dirty),
    .wr_en_i    (wr_en),
    .wr_idx_i   (blk_q),
    .wr_pres_i  (wr_pres),
    .wr_dirty_i (wr_q)
  );

  assign req_oh = NUM_PROC'(1) << req_src_i;
  assign src_oh = NUM_PROC'(1) << src_q;
  assign rsp_oh = NUM_PROC'(1) << rsp_src_i;
  assign inv_oh = NUM_PROC'(1) << inv_idx;
  assign others = rd_pres & ~req_oh;

  dir_lsb #(.W(NUM_PROC)) u_owner (.vec_i(rd_pres), .idx_o(own_idx), .found_o(own_found));
  dir_lsb #(.W(NUM_PROC)) u_inv   (.vec_i(pend_q),  .idx_o(inv_idx), .found_o(inv_found));
  dir_popcnt #(.W(NUM_PROC)) u_cnt (.vec_i(others), .cnt_o(others_cnt));

  assign accept    = req_valid_i && (state_q == ST_IDLE);
  assign inv_phase = (state_q == ST_INV_SEND) || (state_q == ST_INV_WAIT);
  // count each invalidated sharer once
  assign ack_hit   = inv_phase && rsp_valid_i && ((inv_all_q & ~acked_q & rsp_oh) != '0);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (rd_dirty && own_found && (own_idx != req_src_i))  state_d = ST_FETCH;
          else if (req_write_i && !rd_dirty && (others != '0)) state_d = ST_INV_SEND;
          else                                                 state_d = ST_GRANT;
        end
      end
      ST_INV_SEND: if ((pend_q & ~inv_oh) == '0) state_d = ST_INV_WAIT;
      ST_INV_WAIT: if (ack_cnt_q == inv_total_q) state_d = ST_GRANT;
      ST_FETCH:    state_d = ST_OWN_WAIT;
      ST_OWN_WAIT: if (rsp_valid_i && (rsp_src_i == owner_q)) state_d = ST_GRANT;
      ST_GRANT:    state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      src_q       <= '0;
      owner_q     <= '0;
      blk_q       <= '0;
      wr_q        <= 1'b0;
      pend_q      <= '0;
      inv_all_q   <= '0;
      acked_q     <= '0;
      ack_cnt_q   <= '0;
      inv_total_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        src_q       <= req_src_i;
        blk_q       <= req_blk_i;
        wr_q        <= req_write_i;
        owner_q     <= own_idx;
        pend_q      <= others;
        inv_all_q   <= others;
        acked_q     <= '0;
        ack_cnt_q   <= '0;
        inv_total_q <= others_cnt;
      end
      if (state_q == ST_INV_SEND) pend_q <= pend_q & ~inv_oh;
      if (ack_hit) begin
        acked_q   <= acked_q | rsp_oh;
        ack_cnt_q <= ack_cnt_q + 1'b1;
      end
    end
  end

  // directory update on grant: write -> sole owner, read -> add sharer and clean
  assign wr_en   = (state_q == ST_GRANT);
  assign wr_pres = wr_q ? src_oh : (rd_pres | src_oh);

  always_comb begin
    msg_valid_o = 1'b0;
    msg_t       = MSG_NONE;
    msg_dst_o   = '0;
    unique case (state_q)
      ST_INV_SEND: begin
        msg_valid_o = inv_found;
        msg_t       = MSG_INVAL;
        msg_dst_o   = inv_idx;
      end
      ST_FETCH: begin
        msg_valid_o = 1'b1;
        msg_t       = wr_q ? MSG_FETCH_EX : MSG_FETCH_SH;
        msg_dst_o   = owner_q;
      end
      ST_GRANT: begin
        msg_valid_o = 1'b1;
        msg_t       = wr_q ? MSG_DATA_EX : MSG_DATA_SH;
        msg_dst_o   = src_q;
      end
      default: ;
    endcase
  end

  assign msg_type_o   = msg_t;
  assign msg_blk_o    = blk_q;
  assign req_ready_o  = (state_q == ST_IDLE);
  assign done_valid_o = (state_q == ST_GRANT);
  assign done_src_o   = src_q;
  assign done_blk_o   = blk_q;
  assign done_excl_o  = wr_q;

  assert_busy_after_accept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  assert_reopen_after_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_valid_o |=> req_ready_o);

  assert_inv_skips_requester_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && (msg_type_o == MSG_INVAL)) |-> (msg_dst_o != src_q));

  assert_ack_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_phase |-> (ack_cnt_q <= inv_total_q));

  assert_fetch_owner_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FETCH) |-> (rd_dirty && rd_pres[owner_q] && (owner_q != src_q)));

  assert_grant_once_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_valid_o |=> !done_valid_o);
endmodule

// File: tb/tb_dir_home_ctrl.sv
module tb_dir_home_ctrl;
  localparam int NP = 4;
  localparam int NB = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_src = '0;
  logic [2:0] req_blk = '0;
  logic       req_write = 1'b0;
  logic       msg_valid;
  logic [2:0] msg_type;
  logic [1:0] msg_dst;
  logic [2:0] msg_blk;
  logic       rsp_valid = 1'b0;
  logic [1:0] rsp_src = '0;
  logic       done_valid;
  logic [1:0] done_src;
  logic [2:0] done_blk;
  logic       done_excl;

  always #5 clk = ~clk;

  dir_home_ctrl #(.NUM_PROC(NP), .NUM_BLK(NB)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_src_i(req_src),
    .req_blk_i(req_blk), .req_write_i(req_write),
    .msg_valid_o(msg_valid), .msg_type_o(msg_type), .msg_dst_o(msg_dst), .msg_blk_o(msg_blk),
    .rsp_valid_i(rsp_valid), .rsp_src_i(rsp_src),
    .done_valid_o(done_valid), .done_src_o(done_src), .done_blk_o(done_blk), .done_excl_o(done_excl)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // phases: 0 idle, 1 sending invalidations, 2 waiting acks, 3 fetch, 4 owner wait, 5 grant
  int             m_phase, m_src, m_blk, m_owner, m_acks, m_total;
  bit             m_wr;
  bit [NP-1:0]    m_pres [NB];
  bit             m_dirty [NB];
  bit [NP-1:0]    m_inv_all, m_acked;
  int             m_q[$];

  function automatic int low_bit(input bit [NP-1:0] v);
    for (int p = 0; p < NP; p++) if (v[p]) return p;
    return -1;
  endfunction

  task automatic m_count_ack();
    if (rsp_valid && m_inv_all[rsp_src] && !m_acked[rsp_src]) begin
      m_acked[rsp_src] = 1'b1;
      m_acks++;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_acks = 0; m_total = 0; m_q.delete();
      for (int b = 0; b < NB; b++) begin m_pres[b] = '0; m_dirty[b] = 1'b0; end
    end else begin
      case (m_phase)
        0: if (req_valid) begin
          m_src = req_src; m_blk = req_blk; m_wr = req_write;
          if (m_dirty[m_blk] && low_bit(m_pres[m_blk]) != m_src) begin
            m_owner = low_bit(m_pres[m_blk]); m_phase = 3;
          end else if (m_wr && !m_dirty[m_blk]) begin
            m_q.delete(); m_inv_all = '0; m_acked = '0; m_acks = 0;
            for (int p = 0; p < NP; p++)
              if (m_pres[m_blk][p] && p != m_src) begin m_q.push_back(p); m_inv_all[p] = 1'b1; end
            m_total = m_q.size();
            m_phase = (m_total > 0) ? 1 : 5;
          end else m_phase = 5;
        end
        1: begin
          m_count_ack();
          void'(m_q.pop_front());
          if (m_q.size() == 0) m_phase = 2;
        end
        2: begin
          if (m_acks == m_total) m_phase = 5;
          m_count_ack();
        end
        3: m_phase = 4;
        4: if (rsp_valid && rsp_src == m_owner) m_phase = 5;
        5: begin
          if (m_wr) begin
            m_pres[m_blk] = '0; m_pres[m_blk][m_src] = 1'b1; m_dirty[m_blk] = 1'b1;
          end else begin
            m_pres[m_blk][m_src] = 1'b1; m_dirty[m_blk] = 1'b0;
          end
          m_phase = 0;
        end
        default: m_phase = 0;
      endcase
    end
  end

  function automatic string tag_of(input int t);
    case (t)
      1: return "R2";
      2: return "R4";
      3: return "R3";
      4: return "R4";
      5: return "R6";
      default: return "R9";
    endcase
  endfunction

  // per-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit ev; int et, ed;
      ev = 1'b0; et = 0; ed = 0;
      case (m_phase)
        1: begin ev = 1'b1; et = 4; ed = m_q[0]; end
        3: begin ev = 1'b1; et = m_wr ? 5 : 3; ed = m_owner; end
        5: begin ev = 1'b1; et = m_wr ? 2 : 1; ed = m_src; end
        default: ;
      endcase
      chk(req_ready == (m_phase == 0), "R8 ready", req_ready, m_phase == 0);
      chk(msg_valid == ev, {tag_of(et), " msg_valid"}, msg_valid, ev);
      if (ev) begin
        chk(msg_type == 3'(et), {tag_of(et), " msg_type"}, msg_type, et);
        chk(msg_dst == 2'(ed), {tag_of(et), " msg_dst"}, msg_dst, ed);
        chk(msg_blk == 3'(m_blk), {tag_of(et), " msg_blk"}, msg_blk, m_blk);
      end
      chk(done_valid == (m_phase == 5), "R11 done_valid", done_valid, m_phase == 5);
      if (m_phase == 5) begin
        chk(done_src == 2'(m_src), "R11 done_src", done_src, m_src);
        chk(done_blk == 3'(m_blk), "R11 done_blk", done_blk, m_blk);
        chk(done_excl == m_wr, "R11 done_excl", done_excl, m_wr);
      end
    end
  end

  // ---------------- cache responder ----------------
  int rq_src[$];
  int rq_due[$];
  int cyc = 0;
  int stray_req = 0;
  int stray_seen = 0;
  int stray_src = 0;

  always @(negedge clk) begin
    cyc++;
    rsp_valid = 1'b0;
    if (rq_src.size() > 0 && rq_due[0] <= cyc) begin
      rsp_valid = 1'b1;
      rsp_src   = 2'(rq_src.pop_front());
      void'(rq_due.pop_front());
    end else if (stray_seen != stray_req) begin
      rsp_valid = 1'b1;
      rsp_src   = 2'(stray_src);
      stray_seen++;
    end
    if (rst_n && msg_valid && (msg_type == 3'd4 || msg_type == 3'd3 || msg_type == 3'd5)) begin
      rq_src.push_back(int'(msg_dst));
      rq_due.push_back(cyc + 3);
    end
  end

  task automatic txn(input int s, input int b, input bit w, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_src = 2'(s); req_blk = 3'(b); req_write = w;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!done_valid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(msg_valid == 1'b0, "R1 msg_valid", msg_valid, 0);
    chk(done_valid == 1'b0, "R1 done_valid", done_valid, 0);
    rst_n = 1'b1;

    // R2: clean reads build a sharer set
    txn(0, 1, 1'b0, lat); chk(lat == 1, "R2 latency", lat, 1);
    txn(1, 1, 1'b0, lat); chk(lat == 1, "R2 latency", lat, 1);
    txn(2, 1, 1'b0, lat); chk(lat == 1, "R2 latency", lat, 1);

    // R4: write invalidates sharers 0,1,2
    txn(3, 1, 1'b1, lat); chk(lat >= 6, "R4 waits for acks", lat, 6);

    // R5: write with no sharers
    txn(0, 2, 1'b1, lat); chk(lat == 1, "R5 latency", lat, 1);

    // R3/R8/R9: dirty read with stray response and busy request
    @(negedge clk);
    req_valid = 1'b1; req_src = 2'd1; req_blk = 3'd1; req_write = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_src = 2'd0; req_blk = 3'd4; req_write = 1'b1;
    chk(req_ready == 1'b0, "R8 busy ready", req_ready, 0);
    stray_src = 2; stray_req++;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 2;
    while (!done_valid && lat < 200) begin @(negedge clk); lat++; end
    chk(lat >= 4, "R3 owner fetch latency", lat, 4);

    // R9: stray response while idle
    @(negedge clk);
    stray_src = 3; stray_req++;
    repeat (2) @(negedge clk);
    chk(req_ready == 1'b1, "R9 idle stray ready", req_ready, 1);
    chk(msg_valid == 1'b0, "R9 idle stray msg", msg_valid, 0);

    // R4: sharers {1,3}
    txn(2, 1, 1'b1, lat); chk(lat >= 4, "R4 two sharers", lat, 4);
    // R4: requester already a sharer is not invalidated
    txn(1, 3, 1'b0, lat);
    txn(2, 3, 1'b0, lat);
    txn(1, 3, 1'b1, lat); chk(lat >= 3, "R4 self excluded", lat, 3);

    // R10: owner re-requests its dirty block
    txn(0, 2, 1'b1, lat); chk(lat == 1, "R10 owner write", lat, 1);
    txn(0, 2, 1'b0, lat); chk(lat == 1, "R10 owner read", lat, 1);
    txn(1, 2, 1'b0, lat); chk(lat == 1, "R10 block clean after owner read", lat, 1);

    // R6/R7: ownership moves
    txn(3, 5, 1'b1, lat); chk(lat == 1, "R5 latency", lat, 1);
    txn(1, 5, 1'b1, lat); chk(lat >= 4, "R6 fetch-exclusive latency", lat, 4);
    txn(2, 5, 1'b0, lat); chk(lat >= 4, "R7 single owner fetch", lat, 4);
    txn(0, 5, 1'b1, lat); chk(lat >= 4, "R4 after read sharers", lat, 4);
    txn(3, 5, 1'b0, lat); chk(lat >= 4, "R7 fetch from new owner", lat, 4);

    repeat (5) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL R8 watchdog: actual hung expected complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule